// File: doc/BRIEF.md
# Banked Socket Register Window

This block gives a host a two-byte window into the control registers of up to four card sockets. The low byte of the window is a pointer. The host loads it with a register number. The high byte of the window then reads or writes the register that the pointer selects. The pointer byte is divided into a socket field (the upper bits) and a register field (the lower bits). Each socket therefore owns a bank of 64 byte-wide registers. Register r of socket n is found at pointer value n*64 + r.

A two-bit configuration strap sets how many socket banks are populated. An access that points into a bank beyond the populated count behaves as if no register exists there. Registers wider than a byte are kept as adjacent byte pairs, and the host reaches them with two separate pointer/data accesses. Host access uses a simple synchronous byte interface. Read data appears one clock after the read strobe and is held until the next read.

Top module: `sockbank_port`

## Requirements
- R1: After reset the pointer, the read data output and every bank register are 0x00.
- R2: A write with addr0=0 loads wdata into the pointer. A read with addr0=0 returns the pointer value on rdata one cycle later.
- R3: A read with addr0=1 returns the selected register on rdata exactly one cycle after rd_en. rdata keeps its value in every cycle that follows a cycle without rd_en.
- R4: The pointer's bits [7:6] select the socket and bits [5:0] select the register within that socket's bank. Writing one bank leaves the same register number in every other bank unchanged.
- R5: Strap decoding: strap 2'b01 populates socket 0 only; 2'b00 populates sockets 0 and 1; 2'b10 and 2'b11 populate sockets 0 to 3.
- R6: When the pointer selects a socket at or above the populated count, a data read returns 0x00 and a data write changes no register. This remains true if the strap later widens the count.
- R7: A 16-bit value is stored as its low byte at register r and its high byte at register r+1. Each byte is accessed separately, and the pointer never advances by itself.
- R8: When rd_en and wr_en are both asserted with addr0=1 in the same cycle, rdata returns the contents the register had before the write, and the write takes effect.
- R9: The pointer changes only on a write with addr0=0. Data reads and data writes leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strap | input | 2 | Populated socket count strap |
| addr0 | input | 1 | Window byte select: 0 pointer, 1 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |

## Verification
The in-line assertions check a set of properties on every cycle:
- the pointer moves only on a pointer write and takes the written byte;
- rdata holds between reads;
- at most one bank is write-enabled at a time;
- the decoded socket count is always 1, 2 or 4;
- a read from an unpopulated bank returns zero;
- a bank register never changes without its write enable.

The address arithmetic, the read-before-write ordering and the data that actually lands in each bank can only be shown by the bench's scenarios. The bench fills and reads back all 256 locations. It also switches the strap between scenarios to prove that writes to unpopulated banks were discarded.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int unsigned BYTE_W = 8;

    // Populated socket count for a given strap setting
    function automatic logic [2:0] strap_sockets(input logic [1:0] strap);
        case (strap)
            2'b00:   return 3'd2;
            2'b01:   return 3'd1;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sbp_index_reg.sv
module sbp_index_reg #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } idx_state_t;

    idx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx = st_q.ptr;

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(idx));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> idx == $past(load_val));

endmodule

// File: rtl/sbp_bank_decode.sv
module sbp_bank_decode #(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned OFS_W    = 6,
    parameter int unsigned MAX_SOCK = 4,
    localparam int unsigned SOCK_W  = IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        strap,
    output logic [SOCK_W-1:0] sock,
    output logic [OFS_W-1:0]  ofs,
    output logic              active
);
    import sbp_pkg::*;

    logic [2:0] pop_cnt;

    always_comb begin
        pop_cnt = strap_sockets(strap);
        sock    = idx[IDX_W-1:OFS_W];
        ofs     = idx[OFS_W-1:0];
        active  = (32'(sock) < 32'(pop_cnt)) && (32'(sock) < MAX_SOCK);
    end

    // R5
    pop_cnt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 3'd1) || (pop_cnt == 3'd2) || (pop_cnt == 3'd4));

endmodule

// File: rtl/sbp_reg_bank.sv
module sbp_reg_bank #(
    parameter int unsigned OFS_W  = 6,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned REGS  = 1 << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wbyte,
    output logic [DATA_W-1:0] rbyte
);

    typedef struct packed {
        logic [REGS-1:0][DATA_W-1:0] regs;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.regs[ofs] = wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rbyte = st_q.regs[ofs];

    // R6
    bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));

endmodule

// File: rtl/sockbank_port.sv
module sockbank_port #(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned BANK_REGS = 64,
    parameter int unsigned MAX_SOCK  = 4,
    localparam int unsigned DATA_W   = sbp_pkg::BYTE_W,
    localparam int unsigned OFS_W    = $clog2(BANK_REGS),
    localparam int unsigned SOCK_W   = IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_strap,
    input  logic              addr0,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [IDX_W-1:0]              idx;
    logic [SOCK_W-1:0]             sock;
    logic [OFS_W-1:0]              ofs;
    logic                          active;
    logic [MAX_SOCK-1:0]           bank_we;
    logic [MAX_SOCK-1:0][DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0]             sel_byte;

    sbp_index_reg #(.IDX_W(IDX_W)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && !addr0),
        .load_val (IDX_W'(wdata)),
        .idx      (idx)
    );

    sbp_bank_decode #(.IDX_W(IDX_W), .OFS_W(OFS_W), .MAX_SOCK(MAX_SOCK)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (idx),
        .strap  (cfg_strap),
        .sock   (sock),
        .ofs    (ofs),
        .active (active)
    );

    for (genvar s = 0; s < MAX_SOCK; s++) begin : g_bank
        assign bank_we[s] = wr_en && addr0 && active && (32'(sock) == s);
        sbp_reg_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[s]),
            .ofs   (ofs),
            .wbyte (wdata),
            .rbyte (bank_rd[s])
        );
    end

    always_comb begin
        sel_byte = '0;
        for (int s = 0; s < MAX_SOCK; s++) begin
            if (active && 32'(sock) == s) begin
                sel_byte = bank_rd[s];
            end
        end
    end

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd = addr0 ? sel_byte : DATA_W'(idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rd;

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4
    bank_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R6
    empty_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr0 && !active) |=> rdata == '0);

endmodule

// File: tb/tb_sockbank_port.sv
module tb_sockbank_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_strap = 2'b10;
    logic       addr0 = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    logic [7:0] got;

    always #5 clk = ~clk;

    sockbank_port dut (
        .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap), .addr0(addr0),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] pat(input int s, input int r);
        return 8'(((s * 64 + r) * 37) + 11);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic put(input logic a, input logic [7:0] v);
        @(negedge clk);
        addr0 = a; wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic get(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr0 = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr_reg(input int s, input int r, input logic [7:0] v);
        put(1'b0, 8'(s * 64 + r));
        put(1'b1, v);
    endtask

    task automatic rd_reg(input int s, input int r, output logic [7:0] v);
        put(1'b0, 8'(s * 64 + r));
        get(1'b1, v);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        get(1'b0, got);
        check("R1 pointer", got, 8'h00);
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 64; r += 21) begin
                rd_reg(s, r, got);
                check("R1 bank", got, 8'h00);
            end
        end

        // R4 R5 fill every location, four sockets populated
        cfg_strap = 2'b10;
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 64; r++) begin
                wr_reg(s, r, pat(s, r));
            end
        end
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 64; r++) begin
                rd_reg(s, r, got);
                check("R4 bank sweep", got, pat(s, r));
            end
        end

        // R2 pointer readback
        put(1'b0, 8'hA7);
        get(1'b0, got);
        check("R2 pointer readback", got, 8'hA7);

        // R3 hold without rd_en
        put(1'b0, 8'h11);
        check("R3 hold after pointer write", got, rdata);
        repeat (3) @(negedge clk);
        check("R3 hold idle", rdata, 8'hA7);

        // R5 R6 strap 00: sockets 2,3 absent
        cfg_strap = 2'b00;
        for (int s = 2; s < 4; s++) begin
            for (int r = 0; r < 64; r += 31) begin
                wr_reg(s, r, ~pat(s, r));
                rd_reg(s, r, got);
                check("R6 absent bank read", got, 8'h00);
            end
        end
        rd_reg(1, 9, got);
        check("R5 strap00 socket1 present", got, pat(1, 9));
        cfg_strap = 2'b10;
        for (int s = 2; s < 4; s++) begin
            for (int r = 0; r < 64; r += 31) begin
                rd_reg(s, r, got);
                check("R6 absent write ignored", got, pat(s, r));
            end
        end

        // R5 R6 strap 01: only socket 0
        cfg_strap = 2'b01;
        rd_reg(1, 3, got);
        check("R5 strap01 socket1 absent", got, 8'h00);
        wr_reg(1, 3, 8'hEE);
        rd_reg(0, 3, got);
        check("R5 strap01 socket0 present", got, pat(0, 3));
        cfg_strap = 2'b11;
        rd_reg(1, 3, got);
        check("R6 strap01 write ignored", got, pat(1, 3));
        rd_reg(3, 60, got);
        check("R5 strap11 socket3 present", got, pat(3, 60));

        // R8 simultaneous read and write
        put(1'b0, 8'h05);
        @(negedge clk);
        addr0 = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wdata = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 read old value", rdata, pat(0, 5));
        get(1'b1, got);
        check("R8 write landed", got, 8'hC3);

        // R7 R9 16-bit value as byte pair
        wr_reg(1, 10, 8'h34);
        wr_reg(1, 11, 8'h12);
        get(1'b0, got);
        check("R9 pointer unchanged by data", got, 8'h4B);
        get(1'b1, got);
        check("R7 high byte", got, 8'h12);
        get(1'b1, got);
        check("R7 no auto advance", got, 8'h12);
        rd_reg(1, 10, got);
        check("R7 low byte", got, 8'h34);
        rd_reg(0, 10, got);
        check("R4 other bank untouched", got, pat(0, 10));

        finish_run();
    end

endmodule